// File: doc/BRIEF.md
# Indexed Real-Time Clock Registers

This block is a calendar clock that software reaches through two byte ports. A write to the index port selects one internal register. A read of the data port then returns that register one cycle later. Time is kept in binary, 24-hour form: seconds, minutes, hours, weekday, day of month, month and year. All seven fields move forward on a one-second enable input. The starting date and time come from parameters and are loaded at reset. Three status registers return fixed patterns. A status bit in the first of them flips on every read of that register, so a polling loop never waits on it for long.

A separate divider turns the core clock into a one-cycle periodic interrupt pulse, 1024 times per second. Some accesses are not supported: any write to the data port, a read of the index port, a read of the unimplemented fourth status register, and a read of any other unknown index. Each of these produces a one-cycle error indication and changes no state.

The host side is a small state machine. `PS_IDLE` means no response is pending. `PS_DATA` means read data is valid. `PS_FAULT` means the previous access was rejected. Every cycle the next state is chosen from that cycle's request:
- An index write goes to `PS_IDLE`.
- A supported data read goes to `PS_DATA`.
- A rejected access goes to `PS_FAULT`.
- No request goes to `PS_IDLE`.

When a read and a write are requested in the same cycle, the write is taken.

Top module: `rtc_index_regs`

## Requirements
- R1: A write with `port_sel`=0 stores `wdata` as the register index. A read with `port_sel`=1 of a supported index gives `rvalid`=1 and `rdata` in the next cycle, with `err`=0.
- R2: Index 0x0A reads as {flip, 7'h26}. `flip` is 1 after reset and inverts after each read of 0x0A. Reads of other indices and rejected accesses leave it unchanged.
- R3: Index 0x0B always reads 0x46, and index 0x0C always reads 0x00.
- R4: Indices 0x00, 0x02, 0x04, 0x06 and 0x07 read the seconds, minutes, hours, weekday (0-6) and day of month (1-31) in binary. After reset they equal the `INIT_*` parameters.
- R5: Index 0x08 reads the zero-based stored month plus one (1-12). Index 0x09 reads the stored years-since-1900 minus `YEAR_BIAS` (default 52).
- R6: On each cycle with `sec_tick`=1, seconds advance. Seconds and minutes wrap from 59 to 0 with carry, hours wrap from 23 to 0, and the weekday wraps from 6 to 0 on each day change. Without `sec_tick`, no field changes.
- R7: On a day change, the day of month returns to 1 after the month's last day. February has 29 days when the stored year is a multiple of 4, and 28 otherwise. December rolls into January and the year increments.
- R8: `pirq` is a one-cycle pulse every CLK_HZ/PIRQ_HZ cycles (PIRQ_HZ = 1024 by default). The first pulse comes that many cycles after reset.
- R9: A data-port write, an index-port read, or a data read of index 0x0D or any index not listed in R2-R5 gives `err`=1 and `rvalid`=0 in the next cycle, and changes no clock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-second advance enable |
| req_wr | input | 1 | Write request |
| req_rd | input | 1 | Read request |
| port_sel | input | 1 | 0 = index port, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with `rvalid` |
| rvalid | output | 1 | Read response valid |
| err | output | 1 | Access rejected |
| pirq | output | 1 | Periodic interrupt pulse |

## Verification
The bench sets CLK_HZ to 8192, so the periodic divider is 8 and several pulse gaps are measured in a few dozen cycles. It builds three copies of the block with different start parameters, all ending one or two seconds before midnight:
- A leap-year 28 February.
- A common-year 28 February.
- 31 December.

With these values, one or two ticks reach every carry from seconds to years, including the leap-day and year-end rollovers.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hour;
        logic [2:0] wday;
        logic [4:0] mday;
        logic [3:0] mon;   // 0..11
        logic [7:0] year;  // years since 1900
    } rtc_time_t;

    localparam logic [7:0] IX_SEC  = 8'h00;
    localparam logic [7:0] IX_MIN  = 8'h02;
    localparam logic [7:0] IX_HOUR = 8'h04;
    localparam logic [7:0] IX_WDAY = 8'h06;
    localparam logic [7:0] IX_MDAY = 8'h07;
    localparam logic [7:0] IX_MON  = 8'h08;
    localparam logic [7:0] IX_YEAR = 8'h09;
    localparam logic [7:0] IX_STA  = 8'h0A;
    localparam logic [7:0] IX_STB  = 8'h0B;
    localparam logic [7:0] IX_STC  = 8'h0C;

    function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [7:0] year);
        case (mon)
            4'd1:                      month_days = (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd3, 4'd5, 4'd8, 4'd10:   month_days = 5'd30;
            default:                   month_days = 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int INIT_SEC  = 0,
    parameter int INIT_MIN  = 0,
    parameter int INIT_HOUR = 0,
    parameter int INIT_WDAY = 0,
    parameter int INIT_MDAY = 1,
    parameter int INIT_MON  = 0,
    parameter int INIT_YEAR = 106
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sec_tick,
    output rtc_time_t now
);

    rtc_time_t  t_q;
    logic [4:0] dim;

    assign dim = month_days(t_q.mon, t_q.year);
    assign now = t_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.sec  <= 6'(INIT_SEC);
            t_q.min  <= 6'(INIT_MIN);
            t_q.hour <= 5'(INIT_HOUR);
            t_q.wday <= 3'(INIT_WDAY);
            t_q.mday <= 5'(INIT_MDAY);
            t_q.mon  <= 4'(INIT_MON);
            t_q.year <= 8'(INIT_YEAR);
        end else if (sec_tick) begin
            if (t_q.sec != 6'd59) begin
                t_q.sec <= t_q.sec + 6'd1;
            end else begin
                t_q.sec <= '0;
                if (t_q.min != 6'd59) begin
                    t_q.min <= t_q.min + 6'd1;
                end else begin
                    t_q.min <= '0;
                    if (t_q.hour != 5'd23) begin
                        t_q.hour <= t_q.hour + 5'd1;
                    end else begin
                        t_q.hour <= '0;
                        t_q.wday <= (t_q.wday == 3'd6) ? 3'd0 : t_q.wday + 3'd1;
                        if (t_q.mday != dim) begin
                            t_q.mday <= t_q.mday + 5'd1;
                        end else begin
                            t_q.mday <= 5'd1;
                            if (t_q.mon == 4'd11) begin
                                t_q.mon  <= '0;
                                t_q.year <= t_q.year + 8'd1;
                            end else begin
                                t_q.mon <= t_q.mon + 4'd1;
                            end
                        end
                    end
                end
            end
        end
    end

    p_field_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.sec < 6'd60) && (t_q.min < 6'd60) && (t_q.hour < 5'd24) && (t_q.wday < 3'd7));
    p_mday_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.mday >= 5'd1) && (t_q.mday <= dim) && (t_q.mon < 4'd12));
    p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable(t_q));

endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic pirq
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pirq  <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            pirq  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + CW'(1);
            pirq  <= 1'b0;
        end
    end

    int   gap_q;
    logic seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= 0;
            seen_q <= 1'b0;
        end else if (pirq) begin
            gap_q  <= 0;
            seen_q <= 1'b1;
        end else if (gap_q < DIV) begin
            gap_q  <= gap_q + 1;
        end
    end

    p_irq_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pirq && seen_q) |-> (gap_q == DIV - 1));
    p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pirq |=> !pirq);

endmodule

// File: rtl/rtc_host_port.sv
module rtc_host_port
    import rtc_pkg::*;
#(
    parameter int YEAR_BIAS = 52
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_wr,
    input  logic       req_rd,
    input  logic       port_sel,
    input  logic [7:0] wdata,
    input  rtc_time_t  now,
    output logic [7:0] rdata,
    output logic       rvalid,
    output logic       err
);

    typedef enum logic [1:0] {PS_IDLE, PS_DATA, PS_FAULT} port_state_t;

    port_state_t state_q, state_d;
    logic [7:0]  idx_q;
    logic [7:0]  rdata_q;
    logic        flip_q;
    logic        hit;
    logic [7:0]  rd_val;
    logic        sta_read;

    always_comb begin
        hit    = 1'b1;
        rd_val = 8'h00;
        case (idx_q)
            IX_SEC:  rd_val = {2'b00, now.sec};
            IX_MIN:  rd_val = {2'b00, now.min};
            IX_HOUR: rd_val = {3'b000, now.hour};
            IX_WDAY: rd_val = {5'b00000, now.wday};
            IX_MDAY: rd_val = {3'b000, now.mday};
            IX_MON:  rd_val = {4'b0000, now.mon} + 8'd1;
            IX_YEAR: rd_val = now.year - 8'(YEAR_BIAS);
            IX_STA:  rd_val = {flip_q, 7'h26};
            IX_STB:  rd_val = 8'h46;
            IX_STC:  rd_val = 8'h00;
            default: hit = 1'b0;
        endcase
    end

    assign sta_read = !req_wr && req_rd && port_sel && (idx_q == IX_STA);

    always_comb begin
        if (req_wr) begin
            state_d = port_sel ? PS_FAULT : PS_IDLE;
        end else if (req_rd) begin
            state_d = (port_sel && hit) ? PS_DATA : PS_FAULT;
        end else begin
            state_d = PS_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            idx_q   <= '0;
            rdata_q <= '0;
            flip_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            if (req_wr && !port_sel) idx_q <= wdata;
            if (state_d == PS_DATA)  rdata_q <= rd_val;
            if (sta_read)            flip_q <= !flip_q;
        end
    end

    always_comb begin
        rvalid = 1'b0;
        err    = 1'b0;
        rdata  = 8'h00;
        unique case (state_q)
            PS_IDLE:  ;
            PS_DATA:  begin rvalid = 1'b1; rdata = rdata_q; end
            PS_FAULT: err = 1'b1;
            default:  ;
        endcase
    end

    p_flip_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sta_read |=> (flip_q != $past(flip_q)));
    p_resp_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rvalid && err));
    p_data_write_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && port_sel) |=> (err && !rvalid));
    p_index_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && !port_sel) |=> (idx_q == $past(wdata)));

endmodule

// File: rtl/rtc_index_regs.sv
module rtc_index_regs
    import rtc_pkg::*;
#(
    parameter int CLK_HZ    = 125_000_000,
    parameter int PIRQ_HZ   = 1024,
    parameter int YEAR_BIAS = 52,
    parameter int INIT_SEC  = 0,
    parameter int INIT_MIN  = 0,
    parameter int INIT_HOUR = 0,
    parameter int INIT_WDAY = 0,
    parameter int INIT_MDAY = 1,
    parameter int INIT_MON  = 0,
    parameter int INIT_YEAR = 106
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       req_wr,
    input  logic       req_rd,
    input  logic       port_sel,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       rvalid,
    output logic       err,
    output logic       pirq
);

    localparam int DIV = (CLK_HZ / PIRQ_HZ > 1) ? CLK_HZ / PIRQ_HZ : 2;

    rtc_time_t now;

    rtc_calendar #(
        .INIT_SEC (INIT_SEC),  .INIT_MIN (INIT_MIN),  .INIT_HOUR(INIT_HOUR),
        .INIT_WDAY(INIT_WDAY), .INIT_MDAY(INIT_MDAY), .INIT_MON (INIT_MON),
        .INIT_YEAR(INIT_YEAR)
    ) u_cal (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .now(now)
    );

    rtc_periodic #(.DIV(DIV)) u_pdiv (
        .clk(clk), .rst_n(rst_n), .pirq(pirq)
    );

    rtc_host_port #(.YEAR_BIAS(YEAR_BIAS)) u_port (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd),
        .port_sel(port_sel), .wdata(wdata), .now(now),
        .rdata(rdata), .rvalid(rvalid), .err(err)
    );

endmodule

// File: tb/test_rtc_index_regs.sv
module test_rtc_index_regs;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_tick = 1'b0;
    logic req_wr = 1'b0, req_rd = 1'b0, port_sel = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rd_a, rd_b, rd_c;
    logic rv_a, rv_b, rv_c, er_a, er_b, er_c, irq_a, irq_b, irq_c;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic [7:0] cap_a, cap_b, cap_c;
    logic cap_rv, cap_err;

    always #4 clk = ~clk;

    // leap-year Feb 28 23:59:58, Saturday
    rtc_index_regs #(.CLK_HZ(8192), .INIT_SEC(58), .INIT_MIN(59), .INIT_HOUR(23),
        .INIT_WDAY(6), .INIT_MDAY(28), .INIT_MON(1), .INIT_YEAR(104)) i_rtc_index_regs (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .req_wr(req_wr), .req_rd(req_rd),
        .port_sel(port_sel), .wdata(wdata), .rdata(rd_a), .rvalid(rv_a), .err(er_a), .pirq(irq_a));
    // common-year Feb 28 23:59:59, weekday 3
    rtc_index_regs #(.CLK_HZ(8192), .INIT_SEC(59), .INIT_MIN(59), .INIT_HOUR(23),
        .INIT_WDAY(3), .INIT_MDAY(28), .INIT_MON(1), .INIT_YEAR(103)) i_rtc_feb (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .req_wr(req_wr), .req_rd(req_rd),
        .port_sel(port_sel), .wdata(wdata), .rdata(rd_b), .rvalid(rv_b), .err(er_b), .pirq(irq_b));
    // Dec 31 23:59:59 of year 105, weekday 5
    rtc_index_regs #(.CLK_HZ(8192), .INIT_SEC(59), .INIT_MIN(59), .INIT_HOUR(23),
        .INIT_WDAY(5), .INIT_MDAY(31), .INIT_MON(11), .INIT_YEAR(105)) i_rtc_dec (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .req_wr(req_wr), .req_rd(req_rd),
        .port_sel(port_sel), .wdata(wdata), .rdata(rd_c), .rvalid(rv_c), .err(er_c), .pirq(irq_c));

    // {index, expected} for the leap-year copy right after reset
    localparam logic [15:0] VEC [9] = '{
        {8'h00, 8'd58}, {8'h02, 8'd59}, {8'h04, 8'd23}, {8'h06, 8'd6}, {8'h07, 8'd28},
        {8'h08, 8'd2},  {8'h09, 8'd52}, {8'h0B, 8'h46}, {8'h0C, 8'h00}};

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic w, input logic r, input logic sel, input logic [7:0] d);
        req_wr = w; req_rd = r; port_sel = sel; wdata = d;
        @(negedge clk);
        req_wr = 1'b0; req_rd = 1'b0; port_sel = 1'b0; wdata = 8'h00;
        cap_a = rd_a; cap_b = rd_b; cap_c = rd_c;
        cap_rv = rv_a; cap_err = er_a;
    endtask

    task automatic read_ix(input logic [7:0] ix);
        bus_op(1'b1, 1'b0, 1'b0, ix);
        bus_op(1'b0, 1'b1, 1'b1, 8'h00);
    endtask

    task automatic tick();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got 0x00 expected 0x01");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("reset rvalid R1", 8'(rv_a), 8'd0);
        check("reset err R9", 8'(er_a), 8'd0);
        check("reset pirq R8", 8'(irq_a), 8'd0);

        // table walk: R1 R3 R4 R5
        for (int i = 0; i < 9; i++) begin
            read_ix(VEC[i][15:8]);
            check("table rvalid R1", 8'(cap_rv), 8'd1);
            check("table data R4/R5/R3", cap_a, VEC[i][7:0]);
        end

        // R2 flip bit
        read_ix(8'h0A); check("status A first R2", cap_a, 8'hA6);
        read_ix(8'h0B); check("status B R3", cap_a, 8'h46);
        read_ix(8'h0A); check("status A second R2", cap_a, 8'h26);
        bus_op(1'b0, 1'b1, 1'b1, 8'h00); check("status A third R2", cap_a, 8'hA6);

        // R9 rejected accesses
        bus_op(1'b1, 1'b0, 1'b1, 8'h55);
        check("data write err R9", 8'(cap_err), 8'd1);
        check("data write no rvalid R9", 8'(cap_rv), 8'd0);
        read_ix(8'h0D); check("reg D err R9", 8'(cap_err), 8'd1);
        read_ix(8'h01); check("unknown idx err R9", 8'(cap_err), 8'd1);
        read_ix(8'h30); check("unknown idx 0x30 err R9", 8'(cap_err), 8'd1);
        bus_op(1'b0, 1'b1, 1'b0, 8'h00); check("index read err R9", 8'(cap_err), 8'd1);
        read_ix(8'h0A); check("flip untouched by faults R9", cap_a, 8'h26);
        read_ix(8'h00); check("seconds untouched by faults R9", cap_a, 8'd58);

        // R6 hold without tick
        repeat (20) @(negedge clk);
        read_ix(8'h00); check("seconds hold no tick R6", cap_a, 8'd58);

        tick();
        read_ix(8'h00); check("seconds 58->59 R6", cap_a, 8'd59);
        read_ix(8'h07); check("common Feb->Mar 1 R7", cap_b, 8'd1);
        read_ix(8'h08); check("common Feb->Mar month R7", cap_b, 8'd3);
        check("Dec->Jan month R7", cap_c, 8'd1);
        read_ix(8'h09); check("year increment R7", cap_c, 8'd54);
        check("common year unchanged R5", cap_b, 8'd51);

        tick();
        read_ix(8'h00); check("seconds wrap R6", cap_a, 8'd0);
        check("seconds after day R6", cap_b, 8'd1);
        read_ix(8'h02); check("minutes wrap R6", cap_a, 8'd0);
        read_ix(8'h04); check("hours wrap R6", cap_a, 8'd0);
        read_ix(8'h06); check("weekday 6->0 R6", cap_a, 8'd0);
        check("weekday 3->4 R6", cap_b, 8'd4);
        check("weekday 5->6 R6", cap_c, 8'd6);
        read_ix(8'h07); check("leap Feb 29 R7", cap_a, 8'd29);
        check("Dec->Jan day R7", cap_c, 8'd1);
        read_ix(8'h08); check("leap month stays Feb R7", cap_a, 8'd2);
        read_ix(8'h09); check("leap year unchanged R5", cap_a, 8'd52);

        // R8 periodic pulse spacing
        begin
            int gap;
            int cnt;
            int guard;
            guard = 0;
            while (irq_a !== 1'b1 && guard < 50) begin @(negedge clk); guard++; end
            check("pirq seen R8", 8'(irq_a), 8'd1);
            gap = 0;
            do begin @(negedge clk); gap++; end while (irq_a !== 1'b1 && gap < 50);
            check("pirq spacing R8", 8'(gap), 8'd8);
            @(negedge clk);
            check("pirq one cycle R8", 8'(irq_a), 8'd0);
            cnt = 0;
            for (int k = 0; k < 80; k++) begin
                @(negedge clk);
                if (irq_a) cnt++;
            end
            check("pirq count in 80 R8", 8'(cnt), 8'd10);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule